// File: doc/BRIEF.md
# Instrument Status Reporting Register Unit

This unit holds the status-reporting registers of a remotely programmed instrument. Three event groups each keep a latched event register and an enable mask: standard events, questionable-data events and operation events. Device logic drives a level condition vector into each group. A group latches an event bit when its condition bit goes from 0 to 1. The OR of the enabled event bits forms a summary bit. These summaries, a message-available flag and a request-service bit make up an 8-bit status byte. A serial poll reads the status byte from a dedicated output, and software also reads it through the register port.

A service-request enable mask selects which status-byte bits raise the service-request output. A clear-status strobe always empties the event registers. It also asks the external output queue to flush, but only when a program-message terminator came on the cycle just before. The block then masks the message-available bit until the queue reports that it is empty.

Top module: `stat_report_unit`

## Requirements
- R1: Status byte bits 2, 1 and 0 always read 0.
- R2: Status byte bit 3 is 1 exactly when some questionable event bit is set and its questionable enable bit (address 5) is set.
- R3: Status byte bit 4 follows `queue_nonempty`, except that after a flush it is held at 0 from the next cycle until `queue_nonempty` has been seen low at a clock edge.
- R4: Status byte bit 5 is the OR of the standard event register ANDed with the standard enable register (address 3).
- R5: Status byte bit 7 is the OR of the operation event register ANDed with the operation enable register (address 7).
- R6: An event bit is set on the clock edge at which its condition input goes from 0 to 1 (compared with the previous cycle). It then stays set after the condition falls.
- R7: A read of an event address returns the register in the same cycle and clears it at the clock edge. A condition that rises in the read cycle survives the clear.
- R8: Status byte bit 6 is the OR of bits 0–5 and 7, each ANDed with the service-request enable register (address 1). `srq` equals bit 6. Bit 6 of the service-request enable register always reads back as 0.
- R9: `clr_stat` clears all three event registers at the clock edge and leaves every enable register unchanged.
- R10: `queue_flush` is 1 in a cycle with `clr_stat` high exactly when `pmt_strobe` was high in the previous cycle. Otherwise it is 0.
- R11: After reset all event and enable registers read 0, `srq` is 0 and the status byte reads 0x00 while the queue is empty.
- R12: Register map on `rd_addr`/`wr_addr`: 0 status byte (read only), 1 service-request enable, 2/4/6 standard/questionable/operation events (read clears), 3/5/7 the matching enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_cond | input | 8 | Standard event condition levels |
| ques_cond | input | 8 | Questionable condition levels |
| oper_cond | input | 8 | Operation condition levels |
| queue_nonempty | input | 1 | Output queue holds at least one message |
| clr_stat | input | 1 | Clear-status command strobe |
| pmt_strobe | input | 1 | Program-message terminator strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe (clears event registers) |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| status_byte | output | 8 | Status byte for serial poll |
| srq | output | 1 | Service request |
| queue_flush | output | 1 | Request to empty the output queue |

## Verification
The hardest case to reach is a condition that rises in the same cycle as a read-to-clear of its own register. In that cycle the read must still show the old contents, and the next read must show only the new event. The stimulus raises a standard condition bit in the same driver cycle that it issues the event read, then reads again. A second hard case is the terminator gating of the clear command. The bench issues a clear one cycle after a terminator, and a second clear two cycles after one, then follows the message-available bit through the simulated queue emptying and refilling.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int DW   = 8;
  localparam int AW   = 3;
  localparam int NGRP = 3;

  localparam int GRP_STD  = 0;
  localparam int GRP_QUES = 1;
  localparam int GRP_OPER = 2;

  localparam logic [AW-1:0] ADDR_STB = 3'd0;
  localparam logic [AW-1:0] ADDR_SRE = 3'd1;
  localparam int            ADDR_GRP_BASE = 2;

  localparam int SB_QUES = 3;
  localparam int SB_MAV  = 4;
  localparam int SB_STD  = 5;
  localparam int SB_RQS  = 6;
  localparam int SB_OPER = 7;
endpackage

// File: rtl/stat_event_group.sv
module stat_event_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond,
  input  logic         rd_clr,
  input  logic         clr_all,
  input  logic         en_we,
  input  logic [W-1:0] en_wd,
  output logic [W-1:0] ev_q,
  output logic [W-1:0] en_q,
  output logic         summary
);
  logic [W-1:0] cond_q;
  logic [W-1:0] rise;
  logic [W-1:0] ev_d;
  logic [W-1:0] en_d;

  always_comb begin
    rise = cond & ~cond_q;
    ev_d = ev_q;
    if (rd_clr || clr_all) begin
      ev_d = '0;
    end
    ev_d = ev_d | rise;
    en_d = en_q;
    if (en_we) begin
      en_d = en_wd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= '0;
      ev_q   <= '0;
      en_q   <= '0;
    end else begin
      cond_q <= cond;
      ev_q   <= ev_d;
      en_q   <= en_d;
    end
  end

  assign summary = |(ev_q & en_q);
endmodule

// File: rtl/stat_queue_ctl.sv
module stat_queue_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic pmt_strobe,
  input  logic clr_stat,
  input  logic queue_nonempty,
  output logic queue_flush,
  output logic mav
);
  logic armed_q;
  logic kill_q;
  logic kill_d;

  assign queue_flush = clr_stat & armed_q;

  always_comb begin
    kill_d = kill_q;
    if (queue_flush) begin
      kill_d = 1'b1;
    end else if (!queue_nonempty) begin
      kill_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      kill_q  <= 1'b0;
    end else begin
      armed_q <= pmt_strobe;
      kill_q  <= kill_d;
    end
  end

  assign mav = queue_nonempty & ~kill_q;
endmodule

// File: rtl/stat_report_unit.sv
module stat_report_unit
  import stat_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] std_cond,
  input  logic [DW-1:0] ques_cond,
  input  logic [DW-1:0] oper_cond,
  input  logic          queue_nonempty,
  input  logic          clr_stat,
  input  logic          pmt_strobe,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] status_byte,
  output logic          srq,
  output logic          queue_flush
);
  logic [NGRP-1:0][DW-1:0] cond_all;
  logic [NGRP-1:0][DW-1:0] ev_all;
  logic [NGRP-1:0][DW-1:0] en_all;
  logic [NGRP-1:0]         sum_all;
  logic [DW-1:0]           sre_q;
  logic [DW-1:0]           sre_d;
  logic [DW-1:0]           sb_base;
  logic                    mav;
  logic                    rqs;

  assign cond_all[GRP_STD]  = std_cond;
  assign cond_all[GRP_QUES] = ques_cond;
  assign cond_all[GRP_OPER] = oper_cond;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [AW-1:0] EV_A = AW'(ADDR_GRP_BASE + 2*g);
    localparam logic [AW-1:0] EN_A = AW'(ADDR_GRP_BASE + 2*g + 1);
    stat_event_group #(.W(DW)) u_grp (
      .clk     (clk),
      .rst_n   (rst_n),
      .cond    (cond_all[g]),
      .rd_clr  (rd_en && (rd_addr == EV_A)),
      .clr_all (clr_stat),
      .en_we   (wr_en && (wr_addr == EN_A)),
      .en_wd   (wr_data),
      .ev_q    (ev_all[g]),
      .en_q    (en_all[g]),
      .summary (sum_all[g])
    );
  end

  stat_queue_ctl u_qctl (
    .clk            (clk),
    .rst_n          (rst_n),
    .pmt_strobe     (pmt_strobe),
    .clr_stat       (clr_stat),
    .queue_nonempty (queue_nonempty),
    .queue_flush    (queue_flush),
    .mav            (mav)
  );

  always_comb begin
    sre_d = sre_q;
    if (wr_en && (wr_addr == ADDR_SRE)) begin
      sre_d = wr_data;
    end
    sre_d[SB_RQS] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sre_q <= '0;
    end else begin
      sre_q <= sre_d;
    end
  end

  always_comb begin
    sb_base          = '0;
    sb_base[SB_QUES] = sum_all[GRP_QUES];
    sb_base[SB_MAV]  = mav;
    sb_base[SB_STD]  = sum_all[GRP_STD];
    sb_base[SB_OPER] = sum_all[GRP_OPER];
    rqs              = |(sb_base & sre_q);
    status_byte      = sb_base;
    status_byte[SB_RQS] = rqs;
  end

  assign srq = rqs;

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_STB) begin
      rd_data = status_byte;
    end else if (rd_addr == ADDR_SRE) begin
      rd_data = sre_q;
    end else begin
      for (int g = 0; g < NGRP; g++) begin
        if (rd_addr == AW'(ADDR_GRP_BASE + 2*g)) begin
          rd_data = ev_all[g];
        end
        if (rd_addr == AW'(ADDR_GRP_BASE + 2*g + 1)) begin
          rd_data = en_all[g];
        end
      end
    end
  end
endmodule

// File: rtl/stat_report_chk.sv
module stat_report_chk
  import stat_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clr_stat,
  input logic                    pmt_strobe,
  input logic                    wr_en,
  input logic                    queue_nonempty,
  input logic [DW-1:0]           status_byte,
  input logic                    srq,
  input logic                    queue_flush,
  input logic [DW-1:0]           sre_q,
  input logic [NGRP-1:0][DW-1:0] en_all
);
  logic prev_pmt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_pmt <= 1'b0;
    end else begin
      prev_pmt <= pmt_strobe;
    end
  end

  assert_low_bits_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[2:0] == 3'b000);

  assert_mav_needs_queue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !queue_nonempty |-> !status_byte[SB_MAV]);

  assert_mav_drop_after_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
    queue_flush |=> !status_byte[SB_MAV]);

  assert_srq_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    srq |-> ((status_byte & sre_q & 8'hBF) != 8'h00));

  assert_sre_bit6_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sre_q[SB_RQS]);

  assert_enables_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stat && !wr_en) |=> $stable(en_all));

  assert_flush_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stat && !prev_pmt) |-> !queue_flush);

  assert_flush_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stat && prev_pmt) |-> queue_flush);
endmodule

bind stat_report_unit stat_report_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .clr_stat       (clr_stat),
  .pmt_strobe     (pmt_strobe),
  .wr_en          (wr_en),
  .queue_nonempty (queue_nonempty),
  .status_byte    (status_byte),
  .srq            (srq),
  .queue_flush    (queue_flush),
  .sre_q          (sre_q),
  .en_all         (en_all)
);

// File: tb/test_stat_report_unit.sv
module test_stat_report_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] std_cond, ques_cond, oper_cond;
  logic       queue_nonempty, clr_stat, pmt_strobe;
  logic       wr_en, rd_en;
  logic [2:0] wr_addr, rd_addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data, status_byte;
  logic       srq, queue_flush;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  typedef struct {
    string      tag;
    int         kind;
    logic [7:0] exp;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  stat_report_unit i_stat_report_unit (
    .clk(clk), .rst_n(rst_n),
    .std_cond(std_cond), .ques_cond(ques_cond), .oper_cond(oper_cond),
    .queue_nonempty(queue_nonempty), .clr_stat(clr_stat), .pmt_strobe(pmt_strobe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .status_byte(status_byte), .srq(srq), .queue_flush(queue_flush)
  );

  task automatic push(input string tag, input int kind, input logic [7:0] e);
    exp_t it;
    it.tag = tag; it.kind = kind; it.exp = e;
    exp_q.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    tick(); wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    tick(); rd_en = 1'b1; rd_addr = a;
    push(tag, 1, e);
    tick(); rd_en = 1'b0;
  endtask

  // monitor: compares queued expectations away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (exp_q.size() > 0) begin
        exp_t it;
        logic [7:0] act;
        it = exp_q.pop_front();
        case (it.kind)
          0:       act = status_byte;
          1:       act = rd_data;
          2:       act = {7'd0, srq};
          default: act = {7'd0, queue_flush};
        endcase
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; std_cond = '0; ques_cond = '0; oper_cond = '0;
    queue_nonempty = 1'b0; clr_stat = 1'b0; pmt_strobe = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; wr_addr = '0; rd_addr = '0; wr_data = '0;
    tick(); push("R11 status byte in reset", 0, 8'h00); push("R11 srq in reset", 2, 8'h00);
    tick(); rst_n = 1'b1;
    tick(); push("R11 status byte after reset", 0, 8'h00);
    rd(3'd1, 8'h00, "R11 service enable after reset");
    rd(3'd3, 8'h00, "R11 standard enable after reset");
    // R4, R6: standard event
    wr(3'd3, 8'h01);
    tick(); std_cond = 8'h01;
    tick(); std_cond = 8'h00;
    push("R4 standard summary", 0, 8'h20); push("R8 srq masked", 2, 8'h00);
    tick(); push("R6 event held after condition falls", 0, 8'h20);
    // R8: service request
    wr(3'd1, 8'h20);
    push("R8 request bit", 0, 8'h60); push("R8 srq raised", 2, 8'h01);
    wr(3'd1, 8'hFF);
    rd(3'd1, 8'hBF, "R8 enable bit6 reads zero");
    // R7: read to clear
    rd(3'd2, 8'h01, "R7 event readback");
    push("R7 cleared after read", 0, 8'h00); push("R7 srq drops", 2, 8'h00);
    rd(3'd2, 8'h00, "R7 second read empty");
    tick(); std_cond = 8'h02; rd_en = 1'b1; rd_addr = 3'd2;
    push("R7 read during rise shows old", 1, 8'h00);
    tick(); rd_en = 1'b0; std_cond = 8'h00;
    rd(3'd2, 8'h02, "R7 rising event kept");
    rd(3'd0, 8'h00, "R12 status byte address");
    // R2: questionable
    wr(3'd5, 8'h80);
    tick(); ques_cond = 8'h40;
    tick(); push("R2 disabled bit ignored", 0, 8'h00);
    tick(); ques_cond = 8'hC0;
    tick(); push("R2 questionable summary", 0, 8'h48); push("R2 srq", 2, 8'h01);
    // R5: operation
    wr(3'd7, 8'h04);
    tick(); oper_cond = 8'h04;
    tick(); push("R5 operation summary", 0, 8'hC8);
    // R3: message available
    tick(); queue_nonempty = 1'b1; push("R3 message available", 0, 8'hD8);
    // R9/R10: clear without terminator
    tick(); clr_stat = 1'b1; push("R10 no flush without terminator", 3, 8'h00);
    tick(); clr_stat = 1'b0; push("R9 events cleared, queue kept", 0, 8'h50);
    rd(3'd5, 8'h80, "R9 enable unchanged");
    rd(3'd4, 8'h00, "R9 questionable events cleared");
    // R10: clear right after terminator
    tick(); pmt_strobe = 1'b1;
    tick(); pmt_strobe = 1'b0; clr_stat = 1'b1; push("R10 flush after terminator", 3, 8'h01);
    tick(); clr_stat = 1'b0; push("R3 message flag dropped", 0, 8'h00); push("R3 srq dropped", 2, 8'h00);
    tick(); queue_nonempty = 1'b0;
    tick(); queue_nonempty = 1'b1; push("R3 new message after empty", 0, 8'h50);
    // R10: terminator two cycles before
    tick(); pmt_strobe = 1'b1;
    tick(); pmt_strobe = 1'b0;
    tick(); clr_stat = 1'b1; push("R10 late clear no flush", 3, 8'h00);
    tick(); clr_stat = 1'b0; push("R10 message flag kept", 0, 8'h50);
    rd(3'd0, 8'h50, "R12 status byte readback");
    tick(); tick();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule